// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one complete NAND flash operation from a handful of registers. Software first loads the follow-up opcode word, the low and high address registers, the byte count and the tWB delay. It then writes the packed command word. That word holds the opcode, the number of address cycles, the data direction and the chip-enable choice. Writing it with its go bit set starts the operation.

The sequencer then drives the flash pins in this order:

1. It latches the first opcode.
2. It sends the address bytes.
3. It sends the optional confirm opcode and moves the data. For a write, the data goes out before the confirm opcode. For a read, the confirm opcode goes out before the data.
4. It waits the programmed tWB and then waits for the ready/busy line to go high.
5. It reads the data, if the operation reads.

At the end it sets completion flags in a write-one-to-clear interrupt register. Read bytes leave on a strobed output port. Write bytes are pulled one at a time from an input port, with a strobe for each byte taken.

Each bus cycle takes two clocks: a strobe-low clock followed by a strobe-high clock. Error correction, bus mastering and flash timing beyond tWB are handled elsewhere.

Top module: `nand_cmd_seq`

## Requirements
- R1: Writing register 0 with bit 31 set while the engine is idle starts an operation, and `busy` is high from the next clock. A register-0 write with bit 31 clear starts nothing and no strobe follows.
- R2: The first opcode (command-word bits 7:0) is latched with CLE. The address cycles follow with ALE.
  - On a write, the data bytes come next and the confirm opcode last.
  - On a read, or when there is no data phase, the confirm opcode comes straight after the address cycles.
  - Read bytes are fetched only after the ready wait.
- R3: When bit 30 is set, bits 29:27 hold the address cycle count minus one, with the count clamped to 5. Address bytes go out byte 0 first: bits 7:0 then 15:8 of the 16-bit low address register (register 2), then bits 7:0, 15:8 and 23:16 of the 24-bit high address register (register 3).
- R4: Command-word bit 19 set drives `nand_ce_n` = 2'b01 (enable 1) for the whole operation; clear drives 2'b10 (enable 0). Both lines are high when the engine is idle.
- R5: A confirm opcode (register 1 bits 7:0) is issued only when register 1 bit 8 is set.
- R6: Register 4 gives the exact number of data bytes moved, with no minus-one adjustment. Bit 26 selects a read and bit 25 a write. When both are set, the read wins. When neither is set, or the length is 0, there is no data phase.
- R7: After the last command, address or write-data cycle, the engine waits register 5 + 1 clocks. It then waits for `nand_rb` high before reading data or finishing.
- R8: On completion, interrupt bit 31 is set. Bit 28 is also set when the operation was a read. Writing 1 to a bit of register 6 clears it.
- R9: A go write to register 0 while busy is ignored: the running operation continues unchanged. It sets the sticky error bit 0, which is also cleared by writing 1.
- R10: After reset the flags are 0, `busy` is low, both chip enables are high and both strobes are high.
- R11: With command-word bit 30 clear, no address cycle is issued, whatever bits 29:27 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 command, 1 confirm, 2 addr low, 3 addr high, 4 length, 5 tWB, 6 flags) |
| reg_wdata | input | 32 | Register write data |
| irq_status | output | 32 | Flags: bit 31 done, bit 28 read done, bit 0 rejected start |
| busy | output | 1 | Operation in progress |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Data bus in |
| nand_rb | input | 1 | Ready (high) / busy (low) |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| wr_take | output | 1 | Write byte consumed this clock |
| wr_data | input | 8 | Next write byte |

## Verification
The assertions check the following on every clock:
- chip-enable exclusivity, and both enables idle when the engine is not busy;
- mutual exclusion of the two strobes and of CLE and ALE;
- release of the data bus during reads;
- start and ignore on a register-0 write;
- the read-done flag being raised only together with done;
- the error flag rising only while busy;
- write-one-to-clear of the done flag.

The order and content of the latched bytes, the address count and clamp, and the exact data count only show in the bench. It records every write strobe of a flash stub and compares the list with one computed from the register values. The ready wait, the tWB delay and the ignoring of a second start are also shown only by directed bench scenarios that hold ready/busy low or program a long tWB.

// File: rtl/nand_seq_pkg.sv
// Shared constants and types of the NAND command sequencer.
// Assumes a 32-bit register write port and an 8-bit flash bus.
package nand_seq_pkg;

    // Command word field positions
    localparam int GO_BIT       = 31;
    localparam int IRQ_DONE_BIT = 31;
    localparam int IRQ_RDD_BIT  = 28;
    localparam int IRQ_ERR_BIT  = 0;
    localparam int MAX_ADDR     = 5;

    // Register indices
    localparam logic [2:0] RA_CMD  = 3'd0;
    localparam logic [2:0] RA_CONF = 3'd1;
    localparam logic [2:0] RA_ALO  = 3'd2;
    localparam logic [2:0] RA_AHI  = 3'd3;
    localparam logic [2:0] RA_LEN  = 3'd4;
    localparam logic [2:0] RA_TWB  = 3'd5;
    localparam logic [2:0] RA_IRQ  = 3'd6;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_TWB, S_RB, S_RDATA, S_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_CMD, OP_ADDR, OP_WR, OP_RD
    } bus_op_t;

    typedef struct packed {
        logic [7:0] op1;
        logic [7:0] op2;
        logic       op2_en;
        logic       rd;
        logic       wr;
        logic       cs1;
        logic [2:0] naddr;
    } cmd_t;

endpackage

// File: rtl/nand_seq_decode.sv
// Unpacks the command word and confirm word into one operation descriptor.
// Assumes the caller hands in the word on the clock it is written.
module nand_seq_decode
    import nand_seq_pkg::*;
(
    input  logic [5:0] cmd_top,   // word bits 30:25
    input  logic       cs_sel,    // word bit 19
    input  logic [7:0] opcode,    // word bits 7:0
    input  logic [8:0] conf_word, // confirm register bits 8:0
    output cmd_t       cmd
);

    logic [3:0] cnt_raw;

    // Compute address count, clamp, and resolve read priority
    always_comb begin
        cnt_raw    = {1'b0, cmd_top[4:2]} + 4'd1;
        cmd.op1    = opcode;
        cmd.op2    = conf_word[7:0];
        cmd.op2_en = conf_word[8];
        cmd.rd     = cmd_top[1];
        cmd.wr     = cmd_top[0] & ~cmd_top[1];
        cmd.cs1    = cs_sel;
        if (!cmd_top[5])
            cmd.naddr = 3'd0;
        else if (cnt_raw > 4'(MAX_ADDR))
            cmd.naddr = 3'(MAX_ADDR);
        else
            cmd.naddr = cnt_raw[2:0];
    end

endmodule

// File: rtl/nand_seq_regs.sv
// Register file of the sequencer: parameters for the next operation,
// start/reject decode, and write-one-to-clear completion flags.
// Assumes set requests from the engine win over a clear in the same clock.
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int TWB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             busy,
    input  logic             done_set,
    input  logic             rdd_set,
    output logic             start,
    output logic [8:0]       conf_word,
    output logic [15:0]      addr_lo,
    output logic [23:0]      addr_hi,
    output logic [LEN_W-1:0] len,
    output logic [TWB_W-1:0] twb,
    output logic [31:0]      irq_status
);

    logic go_wr, reject, clr_hit;
    logic f_done, f_rdd, f_err;

    // Decode the go write into start or reject
    always_comb begin
        go_wr   = reg_we && (reg_addr == RA_CMD) && reg_wdata[GO_BIT];
        start   = go_wr && !busy;
        reject  = go_wr && busy;
        clr_hit = reg_we && (reg_addr == RA_IRQ);
    end

    // Hold the parameter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conf_word <= '0;
            addr_lo   <= '0;
            addr_hi   <= '0;
            len       <= '0;
            twb       <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CONF: conf_word <= reg_wdata[8:0];
                RA_ALO:  addr_lo   <= reg_wdata[15:0];
                RA_AHI:  addr_hi   <= reg_wdata[23:0];
                RA_LEN:  len       <= reg_wdata[LEN_W-1:0];
                RA_TWB:  twb       <= reg_wdata[TWB_W-1:0];
                default: ;
            endcase
        end
    end

    // Update the sticky flags: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_done <= 1'b0;
            f_rdd  <= 1'b0;
            f_err  <= 1'b0;
        end else begin
            f_done <= (f_done && !(clr_hit && reg_wdata[IRQ_DONE_BIT])) || done_set;
            f_rdd  <= (f_rdd  && !(clr_hit && reg_wdata[IRQ_RDD_BIT]))  || rdd_set;
            f_err  <= (f_err  && !(clr_hit && reg_wdata[IRQ_ERR_BIT]))  || reject;
        end
    end

    // Assemble the flag word
    always_comb begin
        irq_status               = '0;
        irq_status[IRQ_DONE_BIT] = f_done;
        irq_status[IRQ_RDD_BIT]  = f_rdd;
        irq_status[IRQ_ERR_BIT]  = f_err;
    end

endmodule

// File: rtl/nand_seq_fsm.sv
// Phase sequencer: walks opcode, address, data, confirm, tWB and ready wait
// for one latched operation and requests one bus cycle at a time.
// Assumes op_done pulses once per requested bus cycle.
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int TWB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  cmd_t             cmd_in,
    input  logic [15:0]      addr_lo,
    input  logic [23:0]      addr_hi,
    input  logic [LEN_W-1:0] len,
    input  logic [TWB_W-1:0] twb,
    input  logic             nand_rb,
    input  logic             op_done,
    output logic             busy,
    output logic             cs1,
    output logic             op_valid,
    output bus_op_t          op_kind,
    output logic [7:0]       op_byte,
    output logic             done_set,
    output logic             rdd_set
);

    seq_state_t       state, next_state;
    cmd_t             cmd_l;
    logic [39:0]      addr_l;
    logic [LEN_W-1:0] len_l;
    logic [TWB_W-1:0] twb_l, twb_cnt;
    logic [LEN_W-1:0] idx;
    logic             idx_clr, idx_inc;
    logic             idx_last_addr, idx_last_data;
    seq_state_t       post_addr, post_wdata;
    logic [39:0]      addr_sh;

    // Derive the branch targets and the last-cycle compares
    always_comb begin
        post_wdata    = cmd_l.op2_en ? S_CMD2 : S_TWB;
        post_addr     = (cmd_l.wr && (len_l != '0)) ? S_WDATA : post_wdata;
        idx_last_addr = (idx == (LEN_W'(cmd_l.naddr) - LEN_W'(1)));
        idx_last_data = (idx == (len_l - LEN_W'(1)));
        addr_sh       = addr_l >> {idx[2:0], 3'b000};
    end

    // Next state, bus request and completion pulses
    always_comb begin
        next_state = state;
        idx_clr    = 1'b0;
        idx_inc    = 1'b0;
        op_valid   = 1'b0;
        op_kind    = OP_CMD;
        op_byte    = 8'h00;
        done_set   = 1'b0;
        rdd_set    = 1'b0;
        case (state)
            S_IDLE: begin
                if (start) begin
                    next_state = S_CMD1;
                    idx_clr    = 1'b1;
                end
            end
            S_CMD1: begin
                op_valid = 1'b1;
                op_byte  = cmd_l.op1;
                if (op_done) begin
                    idx_clr    = 1'b1;
                    next_state = (cmd_l.naddr != 3'd0) ? S_ADDR : post_addr;
                end
            end
            S_ADDR: begin
                op_valid = 1'b1;
                op_kind  = OP_ADDR;
                op_byte  = addr_sh[7:0];
                if (op_done) begin
                    if (idx_last_addr) begin
                        idx_clr    = 1'b1;
                        next_state = post_addr;
                    end else begin
                        idx_inc = 1'b1;
                    end
                end
            end
            S_WDATA: begin
                op_valid = 1'b1;
                op_kind  = OP_WR;
                if (op_done) begin
                    if (idx_last_data) begin
                        idx_clr    = 1'b1;
                        next_state = post_wdata;
                    end else begin
                        idx_inc = 1'b1;
                    end
                end
            end
            S_CMD2: begin
                op_valid = 1'b1;
                op_byte  = cmd_l.op2;
                if (op_done) next_state = S_TWB;
            end
            S_TWB: begin
                if (twb_cnt == '0) next_state = S_RB;
            end
            S_RB: begin
                if (nand_rb) begin
                    idx_clr    = 1'b1;
                    next_state = (cmd_l.rd && (len_l != '0)) ? S_RDATA : S_FIN;
                end
            end
            S_RDATA: begin
                op_valid = 1'b1;
                op_kind  = OP_RD;
                if (op_done) begin
                    if (idx_last_data) begin
                        idx_clr    = 1'b1;
                        next_state = S_FIN;
                    end else begin
                        idx_inc = 1'b1;
                    end
                end
            end
            S_FIN: begin
                done_set   = 1'b1;
                rdd_set    = cmd_l.rd;
                next_state = S_IDLE;
            end
            default: next_state = S_IDLE;
        endcase
    end

    // Advance the state and the cycle index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
        end else begin
            state <= next_state;
            if (idx_clr)      idx <= '0;
            else if (idx_inc) idx <= idx + LEN_W'(1);
        end
    end

    // Capture the operation parameters when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_l  <= '0;
            addr_l <= '0;
            len_l  <= '0;
            twb_l  <= '0;
        end else if (state == S_IDLE && start) begin
            cmd_l  <= cmd_in;
            addr_l <= {addr_hi, addr_lo};
            len_l  <= len;
            twb_l  <= twb;
        end
    end

    // Count down tWB; reload whenever outside the wait
    always_ff @(posedge clk) begin
        if (!rst_n)               twb_cnt <= '0;
        else if (state != S_TWB)  twb_cnt <= twb_l;
        else if (twb_cnt != '0)   twb_cnt <= twb_cnt - TWB_W'(1);
    end

    assign busy = (state != S_IDLE);
    assign cs1  = cmd_l.cs1;

endmodule

// File: rtl/nand_seq_strobe.sv
// Turns one requested bus cycle into a two-clock strobe on the flash pins:
// strobe low in the first clock, high in the second, then op_done.
// Assumes the request and its byte stay stable until op_done.
module nand_seq_strobe
    import nand_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  bus_op_t    op_kind,
    input  logic [7:0] op_byte,
    input  logic [7:0] wr_data,
    input  logic [7:0] nand_dq_in,
    output logic       op_done,
    output logic       nand_cle,
    output logic       nand_ale,
    output logic       nand_we_n,
    output logic       nand_re_n,
    output logic [7:0] nand_dq_out,
    output logic       nand_dq_oe,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       wr_take
);

    logic phase;
    logic is_rd;

    // Drive pins from the request and the phase
    always_comb begin
        is_rd       = (op_kind == OP_RD);
        nand_cle    = op_valid && (op_kind == OP_CMD);
        nand_ale    = op_valid && (op_kind == OP_ADDR);
        nand_we_n   = !(op_valid && !phase && !is_rd);
        nand_re_n   = !(op_valid && !phase && is_rd);
        nand_dq_oe  = op_valid && !is_rd;
        nand_dq_out = (op_kind == OP_WR) ? wr_data : op_byte;
        op_done     = op_valid && phase;
        rd_valid    = op_valid && phase && is_rd;
        wr_take     = op_valid && phase && (op_kind == OP_WR);
    end

    // Toggle the strobe phase while a cycle is requested
    always_ff @(posedge clk) begin
        if (!rst_n)        phase <= 1'b0;
        else if (op_valid) phase <= !phase;
        else               phase <= 1'b0;
    end

    // Sample the flash bus as the read strobe rises
    always_ff @(posedge clk) begin
        if (!rst_n)                          rd_data <= 8'h00;
        else if (op_valid && !phase && is_rd) rd_data <= nand_dq_in;
    end

endmodule

// File: rtl/nand_cmd_seq.sv
// Top of the NAND command sequencer: register file, command decoder,
// phase sequencer and pin strobe generator.
// Assumes one flash bus shared by two chip enables.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int TWB_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] irq_status,
    output logic        busy,
    output logic [1:0]  nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_in,
    input  logic        nand_rb,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        wr_take,
    input  logic [7:0]  wr_data
);

    logic             start, done_set, rdd_set, op_valid, op_done, cs1;
    logic [8:0]       conf_word;
    logic [15:0]      addr_lo;
    logic [23:0]      addr_hi;
    logic [LEN_W-1:0] len;
    logic [TWB_W-1:0] twb;
    logic [7:0]       op_byte;
    bus_op_t          op_kind;
    cmd_t             cmd;

    nand_seq_regs #(.LEN_W(LEN_W), .TWB_W(TWB_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .done_set(done_set),
        .rdd_set(rdd_set), .start(start), .conf_word(conf_word),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .len(len), .twb(twb),
        .irq_status(irq_status)
    );

    nand_seq_decode u_dec (
        .cmd_top(reg_wdata[30:25]), .cs_sel(reg_wdata[19]),
        .opcode(reg_wdata[7:0]), .conf_word(conf_word), .cmd(cmd)
    );

    nand_seq_fsm #(.LEN_W(LEN_W), .TWB_W(TWB_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(cmd),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .len(len), .twb(twb),
        .nand_rb(nand_rb), .op_done(op_done), .busy(busy), .cs1(cs1),
        .op_valid(op_valid), .op_kind(op_kind), .op_byte(op_byte),
        .done_set(done_set), .rdd_set(rdd_set)
    );

    nand_seq_strobe u_stb (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_byte(op_byte), .wr_data(wr_data), .nand_dq_in(nand_dq_in),
        .op_done(op_done), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_take(wr_take)
    );

    // Select one chip enable while an operation runs
    always_comb begin
        if (!busy)    nand_ce_n = 2'b11;
        else if (cs1) nand_ce_n = 2'b01;
        else          nand_ce_n = 2'b10;
    end

endmodule

// File: rtl/nand_cmd_seq_chk.sv
// Property checker for nand_cmd_seq, attached by bind.
// Assumes the register index map of the sequencer.
module nand_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] irq_status,
    input logic        busy,
    input logic [1:0]  nand_ce_n,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_we_n,
    input logic        nand_re_n,
    input logic        nand_dq_oe,
    input logic        done_set
);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && reg_wdata[31] && !busy) |=> busy); // R1
    AST_NO_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && !reg_wdata[31] && !busy) |=> !busy); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R2
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R2
    AST_CE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~nand_ce_n) <= 1); // R4
    AST_CE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> nand_ce_n == 2'b11); // R4
    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe); // R6
    AST_RDD_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[28]) |-> irq_status[31]); // R8
    AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd6 && reg_wdata[31] && !done_set) |=> !irq_status[31]); // R8
    AST_ERR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[0]) |-> $past(busy)); // R9

endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_status(irq_status), .busy(busy),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe),
    .done_set(done_set)
);

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [2:0] A_CMD = 3'd0, A_CONF = 3'd1, A_ALO = 3'd2,
                           A_AHI = 3'd3, A_LEN = 3'd4, A_TWB = 3'd5, A_IRQ = 3'd6;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] irq_status;
    logic        busy, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [1:0]  nand_ce_n;
    logic [7:0]  nand_dq_out, nand_dq_in, rd_data, wr_data;
    logic        nand_rb, rd_valid, wr_take;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int busy_cnt = 0, rd_idx = 0, wr_idx = 0, rd_seen = 0, log_n = 0, exp_n = 0;
    bit hold_rb = 1'b0;
    logic [11:0] log_q [0:255];
    logic [11:0] exp_q [0:255];

    nand_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .irq_status(irq_status), .busy(busy),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_take(wr_take), .wr_data(wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rpat(input int i);
        return 8'h3C + 8'(i * 5);
    endfunction
    function automatic logic [7:0] wpat(input int i);
        return 8'hA5 ^ 8'(i * 7);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    assign nand_rb    = (busy_cnt == 0) && !hold_rb;
    assign nand_dq_in = rpat(rd_idx);
    assign wr_data    = wpat(wr_idx);

    // Flash stub: log write strobes, model busy, feed reads, check read bytes
    always @(posedge clk) begin
        if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        if (rst_n && !nand_we_n) begin
            if (log_n < 256) log_q[log_n] <= {nand_ce_n, nand_cle, nand_ale, nand_dq_out};
            log_n <= log_n + 1;
            if (nand_cle) busy_cnt <= int'($urandom_range(12, 0));
        end
        if (rst_n && !nand_re_n) rd_idx <= rd_idx + 1;
        if (wr_take) wr_idx <= wr_idx + 1;
        if (rd_valid) begin
            chk("R6 read byte", {24'd0, rd_data}, {24'd0, rpat(rd_seen)});
            rd_seen <= rd_seen + 1;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk("R7 operation ends", {31'd0, busy}, 32'd0);
    endtask

    // Expected write-strobe log from the requirements
    task automatic build_exp(input logic [31:0] a, input logic [31:0] b,
                             input logic [15:0] lo, input logic [23:0] hi, input int len);
        logic [1:0] ce;
        int na;
        logic [39:0] ad;
        ce = a[19] ? 2'b01 : 2'b10;
        na = a[30] ? ((int'(a[29:27]) + 1 > 5) ? 5 : int'(a[29:27]) + 1) : 0;
        ad = {hi, lo};
        exp_n = 0;
        exp_q[exp_n++] = {ce, 2'b10, a[7:0]};
        for (int i = 0; i < na; i++) exp_q[exp_n++] = {ce, 2'b01, ad[i*8 +: 8]};
        if (a[25] && !a[26]) for (int i = 0; i < len; i++) exp_q[exp_n++] = {ce, 2'b00, wpat(i)};
        if (b[8]) exp_q[exp_n++] = {ce, 2'b10, b[7:0]};
    endtask

    task automatic start_op(input logic [31:0] a, input logic [31:0] b, input logic [15:0] lo,
                            input logic [23:0] hi, input int len, input int twb);
        build_exp(a, b, lo, hi, len);
        @(negedge clk);
        log_n <= 0; rd_seen <= 0; rd_idx <= 0; wr_idx <= 0;
        reg_write(A_CONF, b);
        reg_write(A_ALO, {16'd0, lo});
        reg_write(A_AHI, {8'd0, hi});
        reg_write(A_LEN, 32'(len));
        reg_write(A_TWB, 32'(twb));
        reg_write(A_CMD, a);
    endtask

    task automatic finish_op(input string tag, input logic [31:0] a, input int len, input bit do_clear);
        bit rd, wr;
        rd = a[26];
        wr = a[25] && !a[26];
        wait_idle();
        chk({tag, " R2 R3 event count"}, 32'(log_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < 256; i++)
            chk({tag, " R2 R3 R4 R5 R11 event"}, {20'd0, log_q[i]}, {20'd0, exp_q[i]});
        chk({tag, " R6 read count"}, 32'(rd_seen), rd ? 32'(len) : 32'd0);
        chk({tag, " R6 write count"}, 32'(wr_idx), wr ? 32'(len) : 32'd0);
        chk({tag, " R8 done flag"}, {31'd0, irq_status[31]}, 32'd1);
        chk({tag, " R8 read flag"}, {31'd0, irq_status[28]}, {31'd0, rd});
        if (do_clear) begin
            reg_write(A_IRQ, 32'h9000_0001);
            chk({tag, " R8 W1C all"}, irq_status, 32'd0);
        end
    endtask

    initial begin
        int t0;
        logic [31:0] a, b;
        // R10 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 flags", irq_status, 32'd0);
        chk("R10 busy", {31'd0, busy}, 32'd0);
        chk("R10 ce", {30'd0, nand_ce_n}, 32'd3);
        chk("R10 strobes", {30'd0, nand_we_n, nand_re_n}, 32'd3);

        // R1 command word without go bit
        @(negedge clk); log_n <= 0;
        reg_write(A_CMD, 32'h4400_0090);
        repeat (10) @(negedge clk);
        chk("R1 no start busy", {31'd0, busy}, 32'd0);
        chk("R1 no start strobes", 32'(log_n), 32'd0);

        // Status read: one address cycle, one byte
        a = 32'h8000_0070 | (1 << 30) | (1 << 26);
        start_op(a, 32'h0, 16'h00AA, 24'h0, 1, 2);
        finish_op("status R6", a, 1, 1'b1);

        // Five address cycles by clamping field 7, chip enable 1, confirm on
        a = 32'h8000_0000 | (1 << 30) | (7 << 27) | (1 << 26) | (1 << 19);
        start_op(a, 32'h130, 16'hBEEF, 24'h123456, 6, 1);
        finish_op("clamp R3 R4 R5", a, 6, 1'b1);

        // Bit 30 clear: no address even with count field set
        a = 32'h8000_0060 | (3 << 27);
        start_op(a, 32'h1D0, 16'h1111, 24'h222222, 0, 0);
        finish_op("noaddr R11", a, 0, 1'b1);

        // Read and write both set: read wins
        a = 32'h8000_0000 | (1 << 30) | (1 << 27) | (3 << 25);
        start_op(a, 32'h000, 16'h5A5A, 24'h0, 3, 0);
        finish_op("both R6", a, 3, 1'b1);

        // Write with confirm after data
        a = 32'h8000_0080 | (1 << 30) | (4 << 27) | (1 << 25);
        start_op(a, 32'h110, 16'hCAFE, 24'h00BEAD, 9, 3);
        finish_op("write R2", a, 9, 1'b1);

        // Zero-length read: no data, read flag still set; partial clear
        a = 32'h8000_0000 | (1 << 30) | (1 << 26);
        start_op(a, 32'h000, 16'h0001, 24'h0, 0, 0);
        finish_op("zero R6", a, 0, 1'b0);
        reg_write(A_IRQ, 32'h8000_0000);
        chk("R8 partial clear keeps read flag", irq_status, 32'h1000_0000);
        reg_write(A_IRQ, 32'h1000_0000);
        chk("R8 read flag cleared", irq_status, 32'd0);

        // R7 ready/busy held low stalls completion
        hold_rb = 1'b1;
        a = 32'h8000_0060 | (1 << 30) | (2 << 27);
        start_op(a, 32'h1D0, 16'h0102, 24'h000003, 0, 0);
        repeat (40) @(negedge clk);
        chk("R7 stalled busy", {31'd0, busy}, 32'd1);
        chk("R7 stalled no done", {31'd0, irq_status[31]}, 32'd0);
        // R9 second go while busy
        reg_write(A_CMD, 32'h8000_00FF | (1 << 30) | (1 << 26));
        chk("R9 error flag", {31'd0, irq_status[0]}, 32'd1);
        hold_rb = 1'b0;
        finish_op("reject R9", a, 0, 1'b0);
        reg_write(A_IRQ, 32'h0000_0001);
        chk("R9 error cleared", {31'd0, irq_status[0]}, 32'd0);
        reg_write(A_IRQ, 32'h8000_0000);

        // R7 long tWB
        a = 32'h8000_0070 | (1 << 30);
        start_op(a, 32'h0, 16'h0, 24'h0, 0, 40);
        t0 = cyc;
        finish_op("twb R7", a, 0, 1'b1);
        chk("R7 twb elapsed", 32'(cyc - t0 >= 41), 32'd1);

        // Constrained random operations
        process::self().srandom(32'd1234);
        for (int k = 0; k < 30; k++) begin
            int mode, len, twb;
            mode = int'($urandom_range(2, 0));
            len  = int'($urandom_range(16, 0));
            twb  = int'($urandom_range(5, 0));
            a = {1'b1, ($urandom_range(3, 0) != 0), 3'($urandom), (mode == 1), (mode == 2),
                 5'd0, 1'($urandom), 11'd0, 8'($urandom)};
            b = {23'd0, 1'($urandom), 8'($urandom)};
            start_op(a, b, 16'($urandom), 24'($urandom), len, twb);
            finish_op("random", a, len, 1'b1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule